// File: doc/BRIEF.md
# HDLC Address Field Recognizer

This block looks at the address field that opens every received HDLC frame and decides whether the frame is for this station. It receives a byte stream after flag removal and bit destuffing. Each byte comes with a valid strobe, a start-of-frame marker on the first byte and an end-of-frame marker on the last byte. Configuration pins select one-byte or two-byte addressing. They also supply four programmable compare bytes (two for the high address byte, two for the low), a per-byte don't-care mask for each, and a control that removes the command/response bit from the high-byte comparison.

In two-byte mode the high byte is compared with the two programmable high values and with two fixed group values. The low byte is compared with the two programmable low values and with an all-ones value. Six pairings are legal. When a frame matches, the block emits a one-cycle accept pulse carrying the index of the matching pairing, a flag that marks the single pairing meant for autonomous handling, the received command/response bit and a command-or-response indication for one-byte mode. A frame that matches nothing produces no output at all. The input side is valid/ready, but the block never applies back-pressure: `in_ready` is always high, so every byte presented with `in_valid` is consumed in that cycle. The output is a bare strobe with no back-pressure, because the decision has to be acted on as the frame streams past.

Top module: `hdlc_addr_rec`

## Requirements
- R1: In two-byte mode a frame is accepted when its (high, low) address pair equals one of six pairings, reported on `acc_idx` as: 0 = high1/low1, 1 = high1/low2, 2 = high2/low1, 3 = high2/low2, 4 = 0xFE/0xFF, 5 = 0xFC/0xFF. The group high values pair only with a low byte of 0xFF.
- R2: When several pairings match at the same time, `acc_idx` reports the lowest index that matches.
- R3: `acc_auto` is 1 only on an accept in two-byte mode whose index is 0. It is 0 for every other accept.
- R4: With `cfg_cr_ignore` = 1, bit 1 of the high byte is left out of every high-byte comparison, including the group values, and `acc_cr` carries that received bit. With `cfg_cr_ignore` = 0, bit 1 is compared and `acc_cr` is 0.
- R5: A 1 in a mask bit makes that bit position of the corresponding programmable compare byte always compare equal.
- R6: A frame whose address matches no pairing produces no `acc_valid` pulse. While `acc_valid` is 0, all other accept outputs are 0.
- R7: In one-byte mode the single address byte is compared with low1 and low2. A low1 match gives `acc_idx` = 0 and `acc_resp` = 0 (command). A match on low2 only gives `acc_idx` = 1 and `acc_resp` = 1 (response).
- R8: `acc_valid` goes high for exactly one cycle, in the cycle right after the last address byte is taken. Later bytes of the same frame cause no further pulse.
- R9: In two-byte mode, a frame that ends on its first byte is dropped with no accept, and the next frame is recognized normally.
- R10: Configuration is sampled with the start-of-frame byte. Changes later in the frame do not affect that frame's decision.
- R11: `in_ready` is always 1. Bytes that arrive before any start-of-frame, outside a frame, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| cfg_two_byte | input | 1 | 1 = two-byte address, 0 = one-byte |
| cfg_cr_ignore | input | 1 | Excludes high-byte bit 1 from comparison |
| cfg_hi1 | input | 8 | First programmable high compare value |
| cfg_hi2 | input | 8 | Second programmable high compare value |
| cfg_lo1 | input | 8 | First programmable low compare value |
| cfg_lo2 | input | 8 | Second programmable low compare value |
| cfg_hi1_mask | input | 8 | Don't-care bits for cfg_hi1 |
| cfg_hi2_mask | input | 8 | Don't-care bits for cfg_hi2 |
| cfg_lo1_mask | input | 8 | Don't-care bits for cfg_lo1 |
| cfg_lo2_mask | input | 8 | Don't-care bits for cfg_lo2 |
| acc_valid | output | 1 | One-cycle accept strobe |
| acc_idx | output | 3 | Index of the matching pairing |
| acc_auto | output | 1 | Pairing 0 in two-byte mode (autonomous handling) |
| acc_cr | output | 1 | Received command/response bit |
| acc_resp | output | 1 | One-byte mode: 1 = response, 0 = command |

## Verification
The bench drives frames that match several pairings at once, so that a priority encoder ordered the wrong way reports the wrong index. It sends 0xFC/0xFF with C/R exclusion on, where both group values collapse to the same pattern and index 4 must win. It sends a high byte that differs from a programmable value only in bit 1; this has to be rejected when exclusion is off and accepted, with the bit reported, when it is on. It also checks the exact cycle of the pulse on a long frame, where an off-by-one pipeline shows up as a late or doubled strobe. It covers a two-byte frame that ends on its first byte, which a careless design would accept using a stale low byte. It changes the configuration mid-frame, which a design without the sampling register would let flip the verdict. Finally it sends stray bytes outside any frame, which a design that ignores start-of-frame would treat as an address.

// File: rtl/hdlc_addr_pkg.sv
package hdlc_addr_pkg;
  parameter int unsigned ADDR_W    = 8;
  parameter int unsigned NUM_PAIRS = 6;
  localparam int unsigned IDX_W    = $clog2(NUM_PAIRS);

  typedef struct packed {
    logic              two_byte;
    logic              cr_ignore;
    logic [ADDR_W-1:0] hi1;
    logic [ADDR_W-1:0] hi2;
    logic [ADDR_W-1:0] lo1;
    logic [ADDR_W-1:0] lo2;
    logic [ADDR_W-1:0] hi1_m;
    logic [ADDR_W-1:0] hi2_m;
    logic [ADDR_W-1:0] lo1_m;
    logic [ADDR_W-1:0] lo2_m;
  } addr_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_BODY = 2'd2
  } rx_state_t;
endpackage

// File: rtl/hdlc_addr_masked_eq.sv
module hdlc_addr_masked_eq #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] dc,
  output logic         eq
);
  assign eq = ((a ^ b) & ~dc) == '0;
endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match
  import hdlc_addr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] GRP_A  = 8'hFE,
  parameter logic [ADDR_W-1:0] GRP_B  = 8'hFC,
  parameter int unsigned       CR_BIT = 1
) (
  input  addr_cfg_t          cfg,
  input  logic [ADDR_W-1:0]  hi_byte,
  input  logic [ADDR_W-1:0]  lo_byte,
  output logic               hit,
  output logic [IDX_W-1:0]   idx,
  output logic               is_auto,
  output logic               is_resp,
  output logic               cr_bit
);
  localparam int unsigned      NUM_PROG = 4;
  localparam logic [ADDR_W-1:0] CR_MASK = ADDR_W'(1) << CR_BIT;

  logic [ADDR_W-1:0] crm;
  logic [ADDR_W-1:0] ref_v [NUM_PROG];
  logic [ADDR_W-1:0] dc_v  [NUM_PROG];
  logic [ADDR_W-1:0] opnd  [NUM_PROG];
  logic [NUM_PROG-1:0] eqv;
  logic grp_a_eq, grp_b_eq, lo_ones;
  logic [NUM_PAIRS-1:0] pv;

  assign crm = cfg.cr_ignore ? CR_MASK : '0;

  always_comb begin
    ref_v[0] = cfg.hi1;  dc_v[0] = cfg.hi1_m | crm;  opnd[0] = hi_byte;
    ref_v[1] = cfg.hi2;  dc_v[1] = cfg.hi2_m | crm;  opnd[1] = hi_byte;
    ref_v[2] = cfg.lo1;  dc_v[2] = cfg.lo1_m;        opnd[2] = lo_byte;
    ref_v[3] = cfg.lo2;  dc_v[3] = cfg.lo2_m;        opnd[3] = lo_byte;
  end

  for (genvar k = 0; k < NUM_PROG; k++) begin : g_prog
    hdlc_addr_masked_eq #(.W(ADDR_W)) u_eq (
      .a(opnd[k]), .b(ref_v[k]), .dc(dc_v[k]), .eq(eqv[k])
    );
  end

  hdlc_addr_masked_eq #(.W(ADDR_W)) u_grp_a (
    .a(hi_byte), .b(GRP_A), .dc(crm), .eq(grp_a_eq));
  hdlc_addr_masked_eq #(.W(ADDR_W)) u_grp_b (
    .a(hi_byte), .b(GRP_B), .dc(crm), .eq(grp_b_eq));
  hdlc_addr_masked_eq #(.W(ADDR_W)) u_lo_ones (
    .a(lo_byte), .b({ADDR_W{1'b1}}), .dc({ADDR_W{1'b0}}), .eq(lo_ones));

  always_comb begin
    if (cfg.two_byte)
      pv = {grp_b_eq & lo_ones, grp_a_eq & lo_ones,
            eqv[1] & eqv[3], eqv[1] & eqv[2],
            eqv[0] & eqv[3], eqv[0] & eqv[2]};
    else
      pv = {{(NUM_PAIRS-2){1'b0}}, eqv[3], eqv[2]};
  end

  always_comb begin
    idx = '0;
    for (int i = NUM_PAIRS - 1; i >= 0; i--)
      if (pv[i]) idx = IDX_W'(i);
  end

  assign hit     = |pv;
  assign is_auto = cfg.two_byte & pv[0];
  assign is_resp = ~cfg.two_byte & ~pv[0] & pv[1];
  assign cr_bit  = cfg.two_byte & cfg.cr_ignore & hi_byte[CR_BIT];
endmodule

// File: rtl/hdlc_addr_rec.sv
module hdlc_addr_rec
  import hdlc_addr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] GRP_A  = 8'hFE,
  parameter logic [ADDR_W-1:0] GRP_B  = 8'hFC,
  parameter int unsigned       CR_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              cfg_two_byte,
  input  logic              cfg_cr_ignore,
  input  logic [ADDR_W-1:0] cfg_hi1,
  input  logic [ADDR_W-1:0] cfg_hi2,
  input  logic [ADDR_W-1:0] cfg_lo1,
  input  logic [ADDR_W-1:0] cfg_lo2,
  input  logic [ADDR_W-1:0] cfg_hi1_mask,
  input  logic [ADDR_W-1:0] cfg_hi2_mask,
  input  logic [ADDR_W-1:0] cfg_lo1_mask,
  input  logic [ADDR_W-1:0] cfg_lo2_mask,
  output logic              acc_valid,
  output logic [IDX_W-1:0]  acc_idx,
  output logic              acc_auto,
  output logic              acc_cr,
  output logic              acc_resp
);
  addr_cfg_t         cfg_live, cfg_q, cfg_eff;
  rx_state_t         st_q, st_d;
  logic [ADDR_W-1:0] hi_q;
  logic              start, last_addr;
  logic              m_hit, m_auto, m_resp, m_cr;
  logic [IDX_W-1:0]  m_idx;

  assign in_ready = 1'b1;

  assign cfg_live = '{two_byte: cfg_two_byte, cr_ignore: cfg_cr_ignore,
                      hi1: cfg_hi1, hi2: cfg_hi2, lo1: cfg_lo1, lo2: cfg_lo2,
                      hi1_m: cfg_hi1_mask, hi2_m: cfg_hi2_mask,
                      lo1_m: cfg_lo1_mask, lo2_m: cfg_lo2_mask};

  assign start   = in_valid & in_sof;
  assign cfg_eff = start ? cfg_live : cfg_q;

  // last address byte: the opening byte in one-byte mode, the second in two-byte mode
  assign last_addr = in_valid & ((in_sof & ~cfg_eff.two_byte) |
                                 (~in_sof & (st_q == ST_HI)));

  always_comb begin
    st_d = st_q;
    if (start) begin
      if (in_eof)                st_d = ST_IDLE;
      else if (cfg_live.two_byte) st_d = ST_HI;
      else                       st_d = ST_BODY;
    end else if (in_valid && st_q != ST_IDLE) begin
      if (in_eof)                st_d = ST_IDLE;
      else                       st_d = ST_BODY;
    end
  end

  hdlc_addr_match #(.GRP_A(GRP_A), .GRP_B(GRP_B), .CR_BIT(CR_BIT)) u_match (
    .cfg(cfg_eff), .hi_byte(hi_q), .lo_byte(in_data),
    .hit(m_hit), .idx(m_idx), .is_auto(m_auto), .is_resp(m_resp), .cr_bit(m_cr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cfg_q <= '0;
      hi_q  <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        cfg_q <= cfg_live;
        hi_q  <= in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_idx   <= '0;
      acc_auto  <= 1'b0;
      acc_cr    <= 1'b0;
      acc_resp  <= 1'b0;
    end else if (last_addr && m_hit) begin
      acc_valid <= 1'b1;
      acc_idx   <= m_idx;
      acc_auto  <= m_auto;
      acc_cr    <= m_cr;
      acc_resp  <= m_resp;
    end else begin
      acc_valid <= 1'b0;
      acc_idx   <= '0;
      acc_auto  <= 1'b0;
      acc_cr    <= 1'b0;
      acc_resp  <= 1'b0;
    end
  end

  assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_idx < IDX_W'(NUM_PAIRS)));
  assert_auto_pair0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_auto |-> (acc_valid && acc_idx == '0 && !acc_resp));
  assert_cr_with_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cr |-> acc_valid);
  assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (acc_idx == '0 && !acc_auto && !acc_cr && !acc_resp));
  assert_resp_index1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_resp |-> (acc_valid && acc_idx == IDX_W'(1)));
  assert_accept_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid) |-> $past(in_valid));
  assert_short_frame_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_eof && cfg_two_byte) |=> !acc_valid);
  assert_always_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/tb_hdlc_addr_rec.sv
module tb_hdlc_addr_rec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       cfg_two_byte = 1'b1, cfg_cr_ignore = 1'b0;
  logic [7:0] cfg_hi1 = 8'h10, cfg_hi2 = 8'h20, cfg_lo1 = 8'h31, cfg_lo2 = 8'h42;
  logic [7:0] cfg_hi1_mask = 8'h00, cfg_hi2_mask = 8'h00;
  logic [7:0] cfg_lo1_mask = 8'h00, cfg_lo2_mask = 8'h00;
  logic       acc_valid, acc_auto, acc_cr, acc_resp;
  logic [2:0] acc_idx;

  int checks = 0, failures = 0, acc_cnt = 0;
  logic [2:0] l_idx;
  logic l_auto, l_cr, l_resp;

  always #10 clk = ~clk;

  hdlc_addr_rec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .cfg_two_byte(cfg_two_byte), .cfg_cr_ignore(cfg_cr_ignore),
    .cfg_hi1(cfg_hi1), .cfg_hi2(cfg_hi2), .cfg_lo1(cfg_lo1), .cfg_lo2(cfg_lo2),
    .cfg_hi1_mask(cfg_hi1_mask), .cfg_hi2_mask(cfg_hi2_mask),
    .cfg_lo1_mask(cfg_lo1_mask), .cfg_lo2_mask(cfg_lo2_mask),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_auto(acc_auto),
    .acc_cr(acc_cr), .acc_resp(acc_resp)
  );

  always @(negedge clk) if (rst_n && acc_valid) begin
    acc_cnt++;
    l_idx = acc_idx; l_auto = acc_auto; l_cr = acc_cr; l_resp = acc_resp;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_acc(input string req, input bit hit, input int idx,
                            input bit aut, input bit cr, input bit resp);
    if (!hit) begin
      chk(acc_cnt == 0, req, "accept count", acc_cnt, 0);
    end else begin
      chk(acc_cnt == 1, req, "accept count", acc_cnt, 1);
      chk(int'(l_idx) == idx, req, "index", l_idx, idx);
      chk(l_auto == aut, req, "auto", l_auto, aut);
      chk(l_cr == cr, req, "cr", l_cr, cr);
      chk(l_resp == resp, req, "resp", l_resp, resp);
    end
  endtask

  task automatic frame2(input logic [7:0] h, input logic [7:0] l, input string req,
                        input bit hit, input int idx, input bit aut, input bit cr);
    acc_cnt = 0;
    send_byte(h, 1'b1, 1'b0);
    send_byte(l, 1'b0, 1'b0);
    send_byte(8'h5A, 1'b0, 1'b1);
    idle(3);
    expect_acc(req, hit, idx, aut, cr, 1'b0);
  endtask

  task automatic t_reset;
    chk(acc_valid == 1'b0, "R6", "acc_valid after reset", acc_valid, 0);
    chk(in_ready == 1'b1, "R11", "in_ready", in_ready, 1);
  endtask

  task automatic t_pairs;  // R1, R3, R6
    frame2(8'h10, 8'h31, "R3", 1, 0, 1, 0);
    frame2(8'h10, 8'h42, "R1", 1, 1, 0, 0);
    frame2(8'h20, 8'h31, "R1", 1, 2, 0, 0);
    frame2(8'h20, 8'h42, "R1", 1, 3, 0, 0);
    frame2(8'hFE, 8'hFF, "R1", 1, 4, 0, 0);
    frame2(8'hFC, 8'hFF, "R1", 1, 5, 0, 0);
    frame2(8'hFE, 8'h31, "R6", 0, 0, 0, 0);
    frame2(8'h10, 8'h55, "R6", 0, 0, 0, 0);
    frame2(8'h33, 8'h31, "R6", 0, 0, 0, 0);
  endtask

  task automatic t_priority;  // R2
    cfg_hi2 = 8'h10; cfg_lo2 = 8'h31;
    frame2(8'h10, 8'h31, "R2", 1, 0, 1, 0);
    cfg_hi2 = 8'h20;
    frame2(8'h20, 8'h31, "R2", 1, 2, 0, 0);
    cfg_lo2 = 8'h42;
  endtask

  task automatic t_cr;  // R4
    frame2(8'h12, 8'h31, "R4", 0, 0, 0, 0);
    cfg_cr_ignore = 1'b1;
    frame2(8'h12, 8'h31, "R4", 1, 0, 1, 1);
    frame2(8'h10, 8'h31, "R4", 1, 0, 1, 0);
    frame2(8'hFC, 8'hFF, "R4", 1, 4, 0, 0);
    cfg_cr_ignore = 1'b0;
  endtask

  task automatic t_mask;  // R5
    cfg_hi1_mask = 8'h0F;
    frame2(8'h1A, 8'h31, "R5", 1, 0, 1, 0);
    cfg_hi1_mask = 8'h00;
    cfg_lo2_mask = 8'hFF;
    frame2(8'h20, 8'h77, "R5", 1, 3, 0, 0);
    cfg_lo2_mask = 8'h00;
  endtask

  task automatic t_one_byte;  // R7
    cfg_two_byte = 1'b0;
    acc_cnt = 0; send_byte(8'h31, 1, 0); send_byte(8'h99, 0, 1); idle(3);
    expect_acc("R7", 1, 0, 0, 0, 0);
    acc_cnt = 0; send_byte(8'h42, 1, 1); idle(3);
    expect_acc("R7", 1, 1, 0, 0, 1);
    acc_cnt = 0; send_byte(8'h10, 1, 0); send_byte(8'h31, 0, 1); idle(3);
    expect_acc("R7", 0, 0, 0, 0, 0);
    cfg_two_byte = 1'b1;
  endtask

  task automatic t_timing;  // R8
    acc_cnt = 0;
    send_byte(8'h10, 1, 0);
    send_byte(8'h31, 0, 0);
    @(negedge clk);
    chk(acc_valid == 1'b0, "R8", "accept too early", acc_valid, 0);
    send_byte(8'h99, 0, 0);
    @(negedge clk);
    chk(acc_valid == 1'b1, "R8", "accept cycle", acc_valid, 1);
    send_byte(8'hAA, 0, 0);
    send_byte(8'hBB, 0, 1);
    idle(3);
    chk(acc_cnt == 1, "R8", "pulses per frame", acc_cnt, 1);
  endtask

  task automatic t_short;  // R9
    acc_cnt = 0; send_byte(8'h10, 1, 1); send_byte(8'h31, 0, 0); idle(3);
    chk(acc_cnt == 0, "R9", "short frame accepted", acc_cnt, 0);
    frame2(8'h20, 8'h42, "R9", 1, 3, 0, 0);
  endtask

  task automatic t_cfg_hold;  // R10
    acc_cnt = 0;
    send_byte(8'h10, 1, 0);
    send_byte(8'h31, 0, 1);
    cfg_hi1 = 8'h55; cfg_two_byte = 1'b0;
    idle(3);
    expect_acc("R10", 1, 0, 1, 0, 0);
    cfg_hi1 = 8'h10; cfg_two_byte = 1'b1;
  endtask

  task automatic t_stray;  // R11
    acc_cnt = 0; send_byte(8'h10, 0, 0); send_byte(8'h31, 0, 1); idle(3);
    chk(acc_cnt == 0, "R11", "stray bytes accepted", acc_cnt, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_pairs();
    t_priority();
    t_cr();
    t_mask();
    t_one_byte();
    t_timing();
    t_short();
    t_cfg_hold();
    t_stray();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule